// File: doc/BRIEF.md
# Serial Register Port for a Real-Time Clock

This block is the serial-side register interface of a real-time-clock peripheral. A host talks to it over a four-wire serial link. The chip select is active high. The clock idles low. The host drives the outgoing bit on each rising SCK edge, and both ends take in data on each falling edge, most significant bit first. The first byte of every selection is a command. Its upper nibble names a register, and two of its lower bits choose between reading and writing and between a single byte and a run of bytes.

The register space holds 16 addresses. Addresses 0 to 6 are the seven BCD timekeeping bytes: seconds, minutes, hours, weekday, day of month, month and year. The block does not count time. It reads these bytes from a parallel port fed by the external counters and sends every written value back out as a one-cycle strobe. The hour-format bit, the PM bit and the century bit pass through unchanged for the counters to interpret. Address 14 is a general control byte whose bit 5 selects 24-hour mode. Address 15 is a control/status byte that carries two sticky flags, oscillator-stopped and supply-low. All link inputs are resynchronized to the system clock. The flag-set inputs are expected to be synchronous to that clock already.

Top module: `rtc_spi_slave`

## Requirements
- R1: The command byte carries the register address in bits 7:4. Bit 3 = 1 selects a single-byte access and bit 2 = 1 selects a read, so 0xC is a single read, 0x8 a single write, 0x4 a burst read and 0x0 a burst write.
- R2: The link uses clock mode 1 with MSB-first bytes. While the chip select is low, SCK and MOSI have no effect and MISO is 0. MISO is also 0 throughout the command byte. Dropping the select in the middle of a byte discards that byte.
- R3: In a burst, each further byte addresses the next register, and the address wraps from 15 to 0.
- R4: A single access moves exactly one data byte. Any later bytes in the same selection produce no write and read back as 0x00.
- R5: Bit 7 of the seconds register (address 0) always reads as 0.
- R6: Addresses 7 to 13 read as 0x00, and writes to them produce no strobe and change nothing.
- R7: Each data byte written to addresses 0 to 6 raises `tk_wr_en` for exactly one clock, with that address and byte on `tk_wr_addr` and `tk_wr_data`.
- R8: Read data for addresses 0 to 6 comes from a copy of `time_live` taken when the command byte completes. A change on `time_live` during the transfer does not show until the next command.
- R9: Address 14 is an 8-bit read/write control byte and is driven on `ctrl1_q`. Bit 5 of this byte is the 24-hour select.
- R10: Address 15 is driven on `ctrl2_q`. Bit 4 is the oscillator-stop flag and bit 6 is the supply-low flag. A one-clock pulse on the matching set input sets a flag. Writing 0 to a flag bit clears it, and writing 1 leaves it as it is. A set input that is high in the same cycle as a clearing write wins. The other bits store the written value.
- R11: After reset, `ctrl1_q` and `ctrl2_q` are 0x00, MISO is 0 and `tk_wr_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the host, idles low |
| spi_cs | input | 1 | Chip select, active high |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| time_live | input | 56 | Live timekeeping bytes; address i is in bits 8i+7:8i |
| tk_wr_en | output | 1 | One-clock strobe for a written timekeeping byte |
| tk_wr_addr | output | 4 | Address of the written timekeeping byte |
| tk_wr_data | output | 8 | Value of the written timekeeping byte |
| osc_stop_set | input | 1 | Pulse that sets the oscillator-stop flag |
| volt_low_set | input | 1 | Pulse that sets the supply-low flag |
| ctrl1_q | output | 8 | Contents of control byte 14 |
| ctrl2_q | output | 8 | Contents of control/status byte 15 |

## Verification
A hardware set of a status flag can land in the same cycle as a host write to address 15 that clears it. The bench provokes this by holding the oscillator-stop set input high for the whole write transaction, so the set is active on the exact cycle the written byte takes effect. The expected outcome is that the oscillator-stop flag reads 1 afterwards, while the supply-low flag, which was set beforehand and not re-pulsed, is cleared. This is judged both on `ctrl2_q` and by a serial read of address 15. Separately, a burst read overlaps a change of the live time bytes, and the bench expects every byte of that burst to keep the values present at the command.

// File: rtl/rtc_spi_pkg.sv
package rtc_spi_pkg;
  // Command byte field positions
  localparam int unsigned CMD_SINGLE_BIT = 3;
  localparam int unsigned CMD_READ_BIT   = 2;

  // Control register addresses
  localparam int unsigned CTRL1_IDX = 14;
  localparam int unsigned CTRL2_IDX = 15;

  // Status flag positions inside control byte 15
  localparam int unsigned OSC_STOP_BIT = 4;
  localparam int unsigned VOLT_LOW_BIT = 6;

  typedef enum logic [1:0] {
    PH_CMD  = 2'd0,
    PH_DATA = 2'd1,
    PH_DONE = 2'd2
  } phase_e;
endpackage

// File: rtl/rtc_spi_sync.sv
module rtc_spi_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] stage_d;
    if (s == 0) begin : g_first
      assign stage_d = async_in;
    end else begin : g_next
      assign stage_d = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_d;
    end
  end

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/rtc_spi_shift.sv
module rtc_spi_shift #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              sck_s,
  input  logic              mosi_s,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic              miso,
  output logic              byte_vld,
  output logic [BYTE_W-1:0] byte_data
);
  localparam int unsigned       CNT_W    = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam logic [CNT_W-1:0]  LAST_BIT = CNT_W'(BYTE_W - 1);

  logic              sck_q;
  logic              rise, fall;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] rx_q, rx_d;
  logic [BYTE_W-1:0] tx_q, tx_d;
  logic [BYTE_W-1:0] data_q, data_d;
  logic              miso_q, miso_d;
  logic              vld_q, vld_d;

  assign rise = sck_s & ~sck_q;
  assign fall = ~sck_s & sck_q;

  always_comb begin
    cnt_d  = cnt_q;
    rx_d   = rx_q;
    tx_d   = tx_q;
    data_d = data_q;
    miso_d = miso_q;
    vld_d  = 1'b0;
    if (!sel) begin
      cnt_d  = '0;
      miso_d = 1'b0;
    end else begin
      // Leading edge: present the next outgoing bit
      if (rise) begin
        if (cnt_q == '0) begin
          miso_d = tx_byte[BYTE_W-1];
          tx_d   = {tx_byte[BYTE_W-2:0], 1'b0};
        end else begin
          miso_d = tx_q[BYTE_W-1];
          tx_d   = {tx_q[BYTE_W-2:0], 1'b0};
        end
      end
      // Trailing edge: take in the incoming bit
      if (fall) begin
        rx_d = {rx_q[BYTE_W-2:0], mosi_s};
        if (cnt_q == LAST_BIT) begin
          cnt_d  = '0;
          vld_d  = 1'b1;
          data_d = rx_d;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q  <= 1'b0;
      cnt_q  <= '0;
      rx_q   <= '0;
      tx_q   <= '0;
      data_q <= '0;
      miso_q <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      sck_q  <= sck_s;
      cnt_q  <= cnt_d;
      rx_q   <= rx_d;
      tx_q   <= tx_d;
      data_q <= data_d;
      miso_q <= miso_d;
      vld_q  <= vld_d;
    end
  end

  assign miso      = miso_q;
  assign byte_vld  = vld_q;
  assign byte_data = data_q;

  // R2: deselect silences the output on the following cycle
  p_miso_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> !miso_q);
endmodule

// File: rtl/rtc_spi_ctrl.sv
module rtc_spi_ctrl
  import rtc_spi_pkg::*;
#(
  parameter int unsigned BYTE_W   = 8,
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned NUM_TIME = 7
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sel,
  input  logic                       byte_vld,
  input  logic [BYTE_W-1:0]          byte_data,
  input  logic [NUM_TIME*BYTE_W-1:0] time_live,
  input  logic                       osc_set,
  input  logic                       volt_set,
  output logic [BYTE_W-1:0]          tx_byte,
  output logic                       wr_en,
  output logic [ADDR_W-1:0]          wr_addr,
  output logic [BYTE_W-1:0]          wr_data,
  output logic [BYTE_W-1:0]          ctrl1_q,
  output logic [BYTE_W-1:0]          ctrl2_q
);
  localparam logic [ADDR_W-1:0] TIME_END = ADDR_W'(NUM_TIME);
  localparam logic [ADDR_W-1:0] C1_ADDR  = ADDR_W'(CTRL1_IDX);
  localparam logic [ADDR_W-1:0] C2_ADDR  = ADDR_W'(CTRL2_IDX);

  phase_e                              phase_q, phase_d;
  logic [ADDR_W-1:0]                   ptr_q, ptr_d;
  logic                                single_q, single_d;
  logic                                rd_q, rd_d;
  logic [NUM_TIME-1:0][BYTE_W-1:0]     snap_q, snap_d;
  logic                                snap_en;
  logic [BYTE_W-1:0]                   c1_q, c1_d;
  logic [BYTE_W-1:0]                   c2_q, c2_d;
  logic                                c2_wr;
  logic                                wr_en_q, wr_en_d;
  logic [ADDR_W-1:0]                   wr_addr_q, wr_addr_d;
  logic [BYTE_W-1:0]                   wr_data_q, wr_data_d;
  logic [BYTE_W-1:0]                   rd_val;

  // Read data for the current pointer
  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NUM_TIME; i++) begin
      if (ptr_q == ADDR_W'(i)) rd_val = snap_q[i];
    end
    if (ptr_q == '0)     rd_val[BYTE_W-1] = 1'b0;
    if (ptr_q == C1_ADDR) rd_val = c1_q;
    if (ptr_q == C2_ADDR) rd_val = c2_q;
  end

  assign tx_byte = (phase_q == PH_DATA && rd_q) ? rd_val : '0;

  // Transaction sequencing
  always_comb begin
    phase_d   = phase_q;
    ptr_d     = ptr_q;
    single_d  = single_q;
    rd_d      = rd_q;
    snap_en   = 1'b0;
    c1_d      = c1_q;
    c2_wr     = 1'b0;
    wr_en_d   = 1'b0;
    wr_addr_d = wr_addr_q;
    wr_data_d = wr_data_q;
    if (!sel) begin
      phase_d = PH_CMD;
    end else if (byte_vld) begin
      unique case (phase_q)
        PH_CMD: begin
          ptr_d    = byte_data[BYTE_W-1 -: ADDR_W];
          single_d = byte_data[CMD_SINGLE_BIT];
          rd_d     = byte_data[CMD_READ_BIT];
          snap_en  = 1'b1;
          phase_d  = PH_DATA;
        end
        PH_DATA: begin
          if (!rd_q) begin
            if (ptr_q < TIME_END) begin
              wr_en_d   = 1'b1;
              wr_addr_d = ptr_q;
              wr_data_d = byte_data;
            end else if (ptr_q == C1_ADDR) begin
              c1_d = byte_data;
            end else if (ptr_q == C2_ADDR) begin
              c2_wr = 1'b1;
            end
          end
          if (single_q) phase_d = PH_DONE;
          else          ptr_d   = ptr_q + 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign snap_d = time_live;

  // Control/status byte: stored bits plus sticky flags with set priority
  always_comb begin
    c2_d = c2_wr ? byte_data : c2_q;
    c2_d[OSC_STOP_BIT] = (c2_wr ? (c2_q[OSC_STOP_BIT] & byte_data[OSC_STOP_BIT])
                                : c2_q[OSC_STOP_BIT]) | osc_set;
    c2_d[VOLT_LOW_BIT] = (c2_wr ? (c2_q[VOLT_LOW_BIT] & byte_data[VOLT_LOW_BIT])
                                : c2_q[VOLT_LOW_BIT]) | volt_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_CMD;
      ptr_q     <= '0;
      single_q  <= 1'b0;
      rd_q      <= 1'b0;
      c1_q      <= '0;
      c2_q      <= '0;
      wr_en_q   <= 1'b0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
    end else begin
      phase_q   <= phase_d;
      ptr_q     <= ptr_d;
      single_q  <= single_d;
      rd_q      <= rd_d;
      c1_q      <= c1_d;
      c2_q      <= c2_d;
      wr_en_q   <= wr_en_d;
      wr_addr_q <= wr_addr_d;
      wr_data_q <= wr_data_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       snap_q <= '0;
    else if (snap_en) snap_q <= snap_d;
  end

  assign wr_en   = wr_en_q;
  assign wr_addr = wr_addr_q;
  assign wr_data = wr_data_q;
  assign ctrl1_q = c1_q;
  assign ctrl2_q = c2_q;

  // R6: strobes only ever carry timekeeping addresses
  p_wr_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_q |-> (wr_addr_q < TIME_END));

  // R7: one strobe per written byte
  p_wr_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_q |=> !wr_en_q);

  // R4: once a single access is complete no strobe follows
  p_done_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_DONE && $past(phase_q) == PH_DONE) |-> !wr_en_q);

  // R10: a set pulse always leaves its flag high
  p_osc_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(osc_set)) |-> c2_q[OSC_STOP_BIT]);

  p_volt_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(volt_set)) |-> c2_q[VOLT_LOW_BIT]);
endmodule

// File: rtl/rtc_spi_slave.sv
module rtc_spi_slave #(
  parameter int unsigned BYTE_W      = 8,
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned NUM_TIME    = 7,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       spi_sck,
  input  logic                       spi_cs,
  input  logic                       spi_mosi,
  output logic                       spi_miso,
  input  logic [NUM_TIME*BYTE_W-1:0] time_live,
  output logic                       tk_wr_en,
  output logic [ADDR_W-1:0]          tk_wr_addr,
  output logic [BYTE_W-1:0]          tk_wr_data,
  input  logic                       osc_stop_set,
  input  logic                       volt_low_set,
  output logic [BYTE_W-1:0]          ctrl1_q,
  output logic [BYTE_W-1:0]          ctrl2_q
);
  localparam int unsigned LINK_W = 3;

  logic [LINK_W-1:0] link_s;
  logic              cs_s, sck_s, mosi_s;
  logic [BYTE_W-1:0] tx_byte;
  logic              byte_vld;
  logic [BYTE_W-1:0] byte_data;

  rtc_spi_sync #(
    .WIDTH  (LINK_W),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in ({spi_cs, spi_sck, spi_mosi}),
    .sync_out (link_s)
  );

  assign {cs_s, sck_s, mosi_s} = link_s;

  rtc_spi_shift #(
    .BYTE_W (BYTE_W)
  ) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel       (cs_s),
    .sck_s     (sck_s),
    .mosi_s    (mosi_s),
    .tx_byte   (tx_byte),
    .miso      (spi_miso),
    .byte_vld  (byte_vld),
    .byte_data (byte_data)
  );

  rtc_spi_ctrl #(
    .BYTE_W   (BYTE_W),
    .ADDR_W   (ADDR_W),
    .NUM_TIME (NUM_TIME)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel       (cs_s),
    .byte_vld  (byte_vld),
    .byte_data (byte_data),
    .time_live (time_live),
    .osc_set   (osc_stop_set),
    .volt_set  (volt_low_set),
    .tx_byte   (tx_byte),
    .wr_en     (tk_wr_en),
    .wr_addr   (tk_wr_addr),
    .wr_data   (tk_wr_data),
    .ctrl1_q   (ctrl1_q),
    .ctrl2_q   (ctrl2_q)
  );
endmodule

// File: tb/rtc_spi_slave_tb.sv
`timescale 1ns/1ps
module rtc_spi_slave_tb;
  localparam int HALF = 8;  // system clocks per SCK half period

  logic        clk;
  logic        rst_n;
  logic        spi_sck, spi_cs, spi_mosi;
  logic        spi_miso;
  logic [55:0] time_live;
  logic        tk_wr_en;
  logic [3:0]  tk_wr_addr;
  logic [7:0]  tk_wr_data;
  logic        osc_stop_set, volt_low_set;
  logic [7:0]  ctrl1_q, ctrl2_q;

  int vectors = 0;
  int fails   = 0;

  logic [7:0]  exp_rx_q[$];
  string       exp_rx_tag[$];
  logic [11:0] exp_wr_q[$];
  string       exp_wr_tag[$];

  rtc_spi_slave u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .spi_sck      (spi_sck),
    .spi_cs       (spi_cs),
    .spi_mosi     (spi_mosi),
    .spi_miso     (spi_miso),
    .time_live    (time_live),
    .tk_wr_en     (tk_wr_en),
    .tk_wr_addr   (tk_wr_addr),
    .tk_wr_data   (tk_wr_data),
    .osc_stop_set (osc_stop_set),
    .volt_low_set (volt_low_set),
    .ctrl1_q      (ctrl1_q),
    .ctrl2_q      (ctrl2_q)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic expect_wr(input logic [3:0] a, input logic [7:0] d, input string req);
    exp_wr_q.push_back({a, d});
    exp_wr_tag.push_back(req);
  endtask

  // Driver: one selection of n bytes; expected MISO bytes go to the scoreboard
  task automatic run(input int n, input string req, input logic [127:0] tx, input logic [127:0] rx);
    for (int i = 0; i < n; i++) begin
      exp_rx_q.push_back(rx[(n-1-i)*8 +: 8]);
      exp_rx_tag.push_back(req);
    end
    @(negedge clk);
    spi_cs = 1'b1;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      for (int b = 7; b >= 0; b--) begin
        spi_mosi = tx[(n-1-i)*8 + b];
        spi_sck  = 1'b1;
        repeat (HALF) @(negedge clk);
        spi_sck  = 1'b0;
        repeat (HALF) @(negedge clk);
      end
    end
    spi_cs = 1'b0;
    repeat (4*HALF) @(negedge clk);
  endtask

  task automatic drained(input string req);
    chk({req, " pending reads"},  exp_rx_q.size(), 0);
    chk({req, " pending writes"}, exp_wr_q.size(), 0);
  endtask

  // Monitor: MISO bytes sampled at each falling SCK edge
  initial begin
    int         bits;
    logic [7:0] sh;
    bits = 0;
    sh   = '0;
    #1;
    forever begin
      @(negedge spi_sck or negedge spi_cs);
      if (!spi_cs) begin
        bits = 0;
      end else begin
        sh = {sh[6:0], spi_miso};
        bits++;
        if (bits == 8) begin
          bits = 0;
          if (exp_rx_q.size() == 0) begin
            chk("R2 unexpected byte", sh, 8'hxx);
          end else begin
            chk(exp_rx_tag.pop_front(), sh, exp_rx_q.pop_front());
          end
        end
      end
    end
  end

  // Monitor: timekeeping write strobes
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n === 1'b1 && tk_wr_en === 1'b1) begin
        if (exp_wr_q.size() == 0) begin
          chk("R6 R4 stray write", {tk_wr_addr, tk_wr_data}, 12'hxxx);
        end else begin
          chk(exp_wr_tag.pop_front(), {tk_wr_addr, tk_wr_data}, exp_wr_q.pop_front());
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    vectors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    spi_sck = 1'b0; spi_cs = 1'b0; spi_mosi = 1'b0;
    osc_stop_set = 1'b0; volt_low_set = 1'b0;
    // year, month, day, weekday, hours, minutes, seconds (seconds in the low byte)
    time_live = {8'h24, 8'h92, 8'h28, 8'h03, 8'h25, 8'h37, 8'hD9};
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R11 reset state
    chk("R11 miso",  spi_miso, 0);
    chk("R11 ctrl1", ctrl1_q, 8'h00);
    chk("R11 ctrl2", ctrl2_q, 8'h00);
    chk("R11 wr_en", tk_wr_en, 0);

    // R2: clocks while deselected are ignored
    for (int k = 0; k < 10; k++) begin
      spi_mosi = 1'b1; spi_sck = 1'b1;
      repeat (HALF) @(negedge clk);
      spi_sck = 1'b0;
      repeat (HALF) @(negedge clk);
    end
    chk("R2 miso idle", spi_miso, 0);

    // R1 single read of hours
    run(2, "R1", {8'h2C, 8'h00}, {8'h00, 8'h25});
    // R5 seconds bit 7 masked
    run(2, "R5", {8'h0C, 8'h00}, {8'h00, 8'h59});
    drained("R1");

    // R8 burst read with live values changing mid-transfer
    fork
      run(8, "R8", {8'h04, 56'h0}, {8'h00, 8'h59, 8'h37, 8'h25, 8'h03, 8'h28, 8'h92, 8'h24});
      begin
        repeat (200) @(negedge clk);
        time_live = {8'h07, 8'h06, 8'h05, 8'h04, 8'h03, 8'h02, 8'h01};
      end
    join
    run(2, "R8 new capture", {8'h6C, 8'h00}, {8'h00, 8'h07});

    // R4 R7 single write with a trailing byte
    expect_wr(4'd1, 8'h45, "R7");
    run(3, "R4", {8'h18, 8'h45, 8'h99}, 24'h0);
    run(3, "R4", {8'h2C, 8'h00, 8'h00}, {8'h00, 8'h03, 8'h00});
    drained("R4");

    // R7 R6 burst write running into the unused range
    expect_wr(4'd5, 8'h11, "R7");
    expect_wr(4'd6, 8'h22, "R7");
    run(4, "R6", {8'h50, 8'h11, 8'h22, 8'h33}, 32'h0);
    drained("R7");

    // R3 R9 burst write from 12 wrapping past 15
    expect_wr(4'd0, 8'h5A, "R3");
    run(6, "R3", {8'h C0, 8'hAA, 8'hBB, 8'h20, 8'h00, 8'h5A}, 48'h0);
    chk("R9 ctrl1", ctrl1_q, 8'h20);
    chk("R9 ctrl2 after zero write", ctrl2_q, 8'h00);
    drained("R3");

    // R3 R9 burst read wrapping 14,15,0,1
    run(5, "R3", {8'hE4, 32'h0}, {8'h00, 8'h20, 8'h00, 8'h01, 8'h02});
    // R6 unused range reads zero, then reaches 14
    run(9, "R6", {8'h74, 64'h0}, {8'h00, 56'h0, 8'h20});
    drained("R6");

    // R10 flags
    @(negedge clk); osc_stop_set = 1'b1; volt_low_set = 1'b1;
    @(negedge clk); osc_stop_set = 1'b0; volt_low_set = 1'b0;
    @(negedge clk);
    chk("R10 set", ctrl2_q, 8'h50);
    run(2, "R10", {8'hFC, 8'h00}, {8'h00, 8'h50});
    run(2, "R10", {8'hF8, 8'h40}, 16'h0);
    chk("R10 clear osc", ctrl2_q, 8'h40);
    run(2, "R10", {8'hF8, 8'h0F}, 16'h0);
    chk("R10 clear volt", ctrl2_q, 8'h0F);
    run(2, "R10", {8'hF8, 8'h5F}, 16'h0);
    chk("R10 one keeps", ctrl2_q, 8'h0F);

    // R10 set in the same cycle as a clearing write
    @(negedge clk); volt_low_set = 1'b1;
    @(negedge clk); volt_low_set = 1'b0;
    @(negedge clk);
    chk("R10 volt set", ctrl2_q, 8'h4F);
    osc_stop_set = 1'b1;
    run(2, "R10", {8'hF8, 8'h00}, 16'h0);
    osc_stop_set = 1'b0;
    @(negedge clk);
    chk("R10 collision", ctrl2_q, 8'h10);
    run(2, "R10", {8'hFC, 8'h00}, {8'h00, 8'h10});

    // R2 aborted byte, then a clean access
    @(negedge clk);
    spi_cs = 1'b1;
    repeat (HALF) @(negedge clk);
    for (int b = 0; b < 3; b++) begin
      spi_mosi = 1'b1; spi_sck = 1'b1;
      repeat (HALF) @(negedge clk);
      spi_sck = 1'b0;
      repeat (HALF) @(negedge clk);
    end
    spi_cs = 1'b0;
    repeat (4*HALF) @(negedge clk);
    run(2, "R2", {8'h0C, 8'h00}, {8'h00, 8'h01});
    drained("R2");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule